// File: doc/BRIEF.md
# DMA Read Request Issuer

This block is the request side of a host-to-device DMA engine. Software programs a host bus address and a byte length through a small register window. It then writes the control word with the start bit set. The block cuts the transfer into read requests of at most `MAX_REQ_DW` dwords (128 by default, 512 bytes). The requests go out at rising host addresses over a valid/ready channel, and each one carries a tag.

A pool of `NUM_TAGS` tags (8 by default) limits how many reads can be outstanding. A request claims the lowest-numbered free tag. That tag goes back to the pool only when a completion marked as the final one for it arrives. When the pool is empty, issue pauses and later resumes at the same address. Software polls a busy bit. The block pulses an interrupt once every request has been issued and every tag has come back. Returned data is handled elsewhere. Completions reach this block only as a tag plus a final flag.

Top module: `dma_rd_issuer`

## Requirements
- R1: After reset, the status word, the address register and the length register all read 0, `req_valid_o` is low and `irq_o` is low.
- R2: A write to the length register (offset 0xC) stores the byte count rounded up to the next multiple of 4. Reading that offset returns the rounded value.
- R3: A write to offset 0x0 with bit 0 (start) set, while the block is idle, makes status bit 8 (busy) read 1 from the next cycle. Start reads back as 0. Bit 1 (direction) and bit 2 (fixed burst) read back as written.
- R4: The n-th request of a transfer (counting from 0) carries address base + n*0x200. Its dword count is 128, except the last request, which carries the remaining dword count.
- R5: Each request carries the lowest-numbered tag that is currently free. No two outstanding requests ever share a tag.
- R6: While no tag is free, `req_valid_o` stays low. After a tag is freed, issue resumes at the next unissued address and uses the freed tag.
- R7: A completion with `cpl_last_i` low frees nothing. Only a completion with `cpl_last_i` high frees its tag.
- R8: While `req_valid_o` is high and `req_ready_i` is low, address, dword count and tag hold their values and valid stays high.
- R9: A control write while busy has no effect. In particular, a start while busy launches no new requests.
- R10: When all requests have been issued and all tags are free, busy falls and `irq_o` pulses high for exactly one cycle. It rises in the same edge that busy falls. Status bit 9 (done) then reads 1 until the next start.
- R11: A start with a programmed length of 0 issues no requests and still ends with the busy drop and the interrupt pulse of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset (0x0 control/status, 0x8 address, 0xC length) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | ADDR_W | Host address of the request |
| req_dwords_o | output | DW_W | Dword count of the request |
| req_tag_o | output | TAG_W | Tag of the request |
| cpl_valid_i | input | 1 | Completion arrives |
| cpl_tag_i | input | TAG_W | Tag of the completion |
| cpl_last_i | input | 1 | Completion is the final one for its tag |
| irq_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
Tag release and tag allocation can land in the same edge. A final completion can free one tag while an accepted request claims another. The freed tag then becomes the lowest candidate for the very next request. The bench provokes this by returning tag 0 right after the first request is accepted and while issue is still running. The third request must then carry tag 0, not tag 2. The bench also keeps its own record of outstanding tags, so any reuse of a live tag is reported.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_ADDR = 4'h8;
  localparam logic [3:0] OFS_LEN  = 4'hC;

  localparam int unsigned BIT_START = 0;
  localparam int unsigned BIT_DIR   = 1;
  localparam int unsigned BIT_BURST = 2;
  localparam int unsigned BIT_BUSY  = 8;
  localparam int unsigned BIT_DONE  = 9;

  typedef struct packed {
    logic dir;
    logic burst;
  } ctl_t;
endpackage

// File: rtl/dma_rd_regs.sv
module dma_rd_regs
  import dma_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              done_set_i,
  output logic              start_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  bytes_o
);
  ctl_t              ctl_q;
  logic              done_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              ctl_we;

  assign ctl_we  = wr_i && (addr_i == OFS_CTRL) && !busy_i;
  assign start_o = ctl_we && wdata_i[BIT_START];
  assign base_o  = base_q;
  assign bytes_o = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.dir   <= wdata_i[BIT_DIR];
        ctl_q.burst <= wdata_i[BIT_BURST];
      end
      if (wr_i && addr_i == OFS_ADDR) base_q <= wdata_i[ADDR_W-1:0];
      // round to whole dwords
      if (wr_i && addr_i == OFS_LEN)
        len_q <= {wdata_i[LEN_W-1:2] + (LEN_W-2)'(|wdata_i[1:0]), 2'b00};
      if (start_o)         done_q <= 1'b0;
      else if (done_set_i) done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_DIR]   = ctl_q.dir;
        rdata_o[BIT_BURST] = ctl_q.burst;
        rdata_o[BIT_BUSY]  = busy_i;
        rdata_o[BIT_DONE]  = done_q;
      end
      OFS_ADDR: rdata_o = 32'(base_q);
      OFS_LEN:  rdata_o = 32'(len_q);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_rd_tag_pool.sv
module dma_rd_tag_pool #(
  parameter int unsigned NUM_TAGS = 8,
  parameter int unsigned TAG_W    = $clog2(NUM_TAGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                want_i,
  input  logic                fire_i,
  input  logic                rel_i,
  input  logic [TAG_W-1:0]    rel_tag_i,
  output logic                avail_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic                all_free_o,
  output logic [NUM_TAGS-1:0] free_o
);
  logic [NUM_TAGS-1:0] free_q, free_n;
  logic [TAG_W-1:0]    low_tag, held_tag_q;
  logic                held_q;

  always_comb begin
    low_tag = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--)
      if (free_q[i]) low_tag = TAG_W'(i);
  end

  // an offered tag stays put until accepted
  assign tag_o      = held_q ? held_tag_q : low_tag;
  assign avail_o    = |free_q;
  assign all_free_o = &free_q;
  assign free_o     = free_q;

  always_comb begin
    free_n = free_q;
    if (rel_i && 32'(rel_tag_i) < NUM_TAGS) free_n[rel_tag_i] = 1'b1;
    if (fire_i) free_n[tag_o] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q     <= '1;
      held_q     <= 1'b0;
      held_tag_q <= '0;
    end else begin
      free_q     <= free_n;
      held_q     <= want_i && avail_o && !fire_i;
      held_tag_q <= tag_o;
    end
  end
endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned MAX_REQ_DW = 128,
  parameter int unsigned DW_W       = $clog2(MAX_REQ_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  bytes_i,
  input  logic              avail_i,
  input  logic              ready_i,
  input  logic              all_free_i,
  output logic              want_o,
  output logic              valid_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW_W-1:0]   dw_o,
  output logic              busy_o,
  output logic              finish_o
);
  localparam int unsigned LEFT_W    = LEN_W - 2;
  localparam int unsigned REQ_BYTES = MAX_REQ_DW * 4;

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEFT_W-1:0] left_q;

  assign want_o   = active_q && (left_q != '0);
  assign valid_o  = want_o && avail_i;
  assign fire_o   = valid_o && ready_i;
  assign addr_o   = addr_q;
  assign dw_o     = (left_q > LEFT_W'(MAX_REQ_DW)) ? DW_W'(MAX_REQ_DW) : DW_W'(left_q);
  assign busy_o   = active_q;
  assign finish_o = active_q && (left_q == '0) && all_free_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      addr_q   <= base_i;
      left_q   <= bytes_i[LEN_W-1:2];
    end else if (fire_o) begin
      addr_q <= addr_q + ADDR_W'(REQ_BYTES);
      left_q <= left_q - LEFT_W'(dw_o);
    end else if (finish_o) begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_rd_issuer.sv
module dma_rd_issuer #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned MAX_REQ_DW = 128,
  parameter int unsigned NUM_TAGS   = 8,
  localparam int unsigned TAG_W     = $clog2(NUM_TAGS),
  localparam int unsigned DW_W      = $clog2(MAX_REQ_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DW_W-1:0]   req_dwords_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              cpl_valid_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic              cpl_last_i,
  output logic              irq_o
);
  logic                start, busy, finish, want, fire, avail, all_free;
  logic [ADDR_W-1:0]   base;
  logic [LEN_W-1:0]    bytes;
  logic [NUM_TAGS-1:0] tag_free;
  logic                irq_q;

  dma_rd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_set_i(finish),
    .start_o(start), .base_o(base), .bytes_o(bytes)
  );

  dma_rd_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_REQ_DW(MAX_REQ_DW), .DW_W(DW_W)) u_split (
    .clk_i, .rst_ni,
    .start_i(start), .base_i(base), .bytes_i(bytes),
    .avail_i(avail), .ready_i(req_ready_i), .all_free_i(all_free),
    .want_o(want), .valid_o(req_valid_o), .fire_o(fire),
    .addr_o(req_addr_o), .dw_o(req_dwords_o),
    .busy_o(busy), .finish_o(finish)
  );

  dma_rd_tag_pool #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .want_i(want), .fire_i(fire),
    .rel_i(cpl_valid_i && cpl_last_i), .rel_tag_i(cpl_tag_i),
    .avail_o(avail), .tag_o(req_tag_o), .all_free_o(all_free), .free_o(tag_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= finish;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/dma_rd_issuer_chk.sv
module dma_rd_issuer_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_REQ_DW = 128,
  parameter int unsigned NUM_TAGS   = 8,
  parameter int unsigned TAG_W      = 3,
  parameter int unsigned DW_W       = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [ADDR_W-1:0]   req_addr_o,
  input logic [DW_W-1:0]     req_dwords_o,
  input logic [TAG_W-1:0]    req_tag_o,
  input logic                irq_o,
  input logic                busy_i,
  input logic [NUM_TAGS-1:0] free_i
);
  a_r1_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !req_valid_o);
  a_r4_dw_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_dwords_o != '0) && (32'(req_dwords_o) <= MAX_REQ_DW));
  a_r5_tag_is_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> free_i[req_tag_o]);
  a_r6_stall_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i == '0) |-> !req_valid_o);
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_dwords_o) && $stable(req_tag_o));
  a_r10_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r10_irq_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !busy_i && $fell(busy_i));
endmodule

bind dma_rd_issuer dma_rd_issuer_chk #(
  .ADDR_W(ADDR_W), .MAX_REQ_DW(MAX_REQ_DW), .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .DW_W(DW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_addr_o(req_addr_o), .req_dwords_o(req_dwords_o), .req_tag_o(req_tag_o),
  .irq_o(irq_o), .busy_i(busy), .free_i(tag_free)
);

// File: tb/dma_rd_issuer_tb.sv
`timescale 1ns/1ps
module dma_rd_issuer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [31:0] req_addr_o;
  logic [7:0]  req_dwords_o;
  logic [2:0]  req_tag_o;
  logic        cpl_valid_i = 1'b0;
  logic [2:0]  cpl_tag_i = '0;
  logic        cpl_last_i = 1'b0;
  logic        irq_o;

  int checks = 0, fails = 0;
  int n_req = 0, irq_cnt = 0, dup_err = 0;
  logic [31:0] r_addr [0:63];
  logic [7:0]  r_dw   [0:63];
  logic [2:0]  r_tag  [0:63];
  logic [7:0]  outst = '0;

  always #10 clk_i = ~clk_i;

  dma_rd_issuer u_dut (.*);

  // request/completion monitor
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (cpl_valid_i && cpl_last_i) outst[cpl_tag_i] = 1'b0;
      if (req_valid_o && req_ready_i) begin
        if (outst[req_tag_o]) dup_err++;
        outst[req_tag_o] = 1'b1;
        if (n_req < 64) begin
          r_addr[n_req] = req_addr_o;
          r_dw[n_req]   = req_dwords_o;
          r_tag[n_req]  = req_tag_o;
        end
        n_req++;
      end
      if (irq_o) irq_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cpl(input logic [2:0] t, input logic last);
    @(negedge clk_i);
    cpl_valid_i = 1'b1; cpl_tag_i = t; cpl_last_i = last;
    @(negedge clk_i);
    cpl_valid_i = 1'b0; cpl_last_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R1 status", d, 0);
    rd(4'h8, d); chk("R1 addr", d, 0);
    rd(4'hC, d); chk("R1 len", d, 0);
    chk("R1 valid", 32'(req_valid_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_round;
    logic [31:0] d;
    wr(4'hC, 32'hFF5); rd(4'hC, d); chk("R2 round up", d, 32'hFF8);
    wr(4'hC, 32'h10);  rd(4'hC, d); chk("R2 exact", d, 32'h10);
  endtask

  // 1280 bytes -> 128,128,64 dwords; tag 0 returns during issue
  task automatic t_basic;
    logic [31:0] d;
    int b = n_req, ic = irq_cnt;
    req_ready_i = 1'b1;
    wr(4'h8, 32'h3790_0000);
    wr(4'hC, 32'd1280);
    wr(4'h0, 32'h7);
    cpl(3'd0, 1'b1);
    rd(4'h0, d);
    chk("R3 busy", 32'(d[8]), 1);
    chk("R3 start self-clears", 32'(d[0]), 0);
    chk("R3 dir/burst", 32'(d[2:1]), 3);
    idle(8);
    chk("R4 count", n_req - b, 3);
    chk("R4 addr0", r_addr[b], 32'h3790_0000);
    chk("R4 addr1", r_addr[b+1], 32'h3790_0200);
    chk("R4 addr2", r_addr[b+2], 32'h3790_0400);
    chk("R4 dw0", 32'(r_dw[b]), 128);
    chk("R4 dw last", 32'(r_dw[b+2]), 64);
    chk("R5 tag0", 32'(r_tag[b]), 0);
    chk("R5 tag1", 32'(r_tag[b+1]), 1);
    chk("R5 reuse freed tag", 32'(r_tag[b+2]), 0);
    wr(4'h8, 32'h0000_1000);
    wr(4'h0, 32'h1);
    idle(6);
    chk("R9 start while busy", n_req - b, 3);
    rd(4'h0, d); chk("R9 ctrl while busy", 32'(d[2:1]), 3);
    cpl(3'd0, 1'b0);
    idle(3);
    rd(4'h0, d); chk("R7 partial keeps busy", 32'(d[8]), 1);
    cpl(3'd0, 1'b1);
    rd(4'h0, d); chk("R10 busy until all tags", 32'(d[8]), 1);
    cpl(3'd1, 1'b1);
    idle(4);
    rd(4'h0, d);
    chk("R10 busy falls", 32'(d[8]), 0);
    chk("R10 done", 32'(d[9]), 1);
    chk("R10 one irq", irq_cnt - ic, 1);
  endtask

  // 10 requests against 8 tags
  task automatic t_exhaust;
    logic [31:0] d;
    int b = n_req, ic = irq_cnt;
    req_ready_i = 1'b1;
    wr(4'h8, 32'h0040_0000);
    wr(4'hC, 32'd5120);
    wr(4'h0, 32'h1);
    idle(20);
    chk("R6 stall at pool size", n_req - b, 8);
    chk("R6 valid low", 32'(req_valid_o), 0);
    for (int i = 0; i < 8; i++) chk("R5 tag order", 32'(r_tag[b+i]), i);
    cpl(3'd3, 1'b0);
    idle(4);
    chk("R7 non-last frees nothing", n_req - b, 8);
    cpl(3'd3, 1'b1);
    idle(4);
    chk("R6 resume count", n_req - b, 9);
    chk("R6 resume addr", r_addr[b+8], 32'h0040_1000);
    chk("R6 resume tag", 32'(r_tag[b+8]), 3);
    cpl(3'd5, 1'b1);
    idle(4);
    chk("R6 second resume addr", r_addr[b+9], 32'h0040_1200);
    chk("R6 second resume tag", 32'(r_tag[b+9]), 5);
    chk("R4 full last", 32'(r_dw[b+9]), 128);
    idle(4);
    chk("R4 no extra", n_req - b, 10);
    for (int t = 0; t < 8; t++) cpl(3'(t), 1'b1);
    idle(4);
    rd(4'h0, d);
    chk("R10 busy falls", 32'(d[8]), 0);
    chk("R10 one irq", irq_cnt - ic, 1);
  endtask

  task automatic t_backpressure;
    logic [31:0] d;
    logic [31:0] a0; logic [7:0] w0; logic [2:0] t0;
    int b = n_req;
    req_ready_i = 1'b0;
    wr(4'h8, 32'h2000_0040);
    wr(4'hC, 32'd13);
    wr(4'h0, 32'h1);
    idle(1);
    chk("R8 valid", 32'(req_valid_o), 1);
    a0 = req_addr_o; w0 = req_dwords_o; t0 = req_tag_o;
    chk("R2 dw from 13 bytes", 32'(w0), 4);
    idle(5);
    chk("R8 valid held", 32'(req_valid_o), 1);
    chk("R8 addr held", req_addr_o, a0);
    chk("R8 dw held", 32'(req_dwords_o), 32'(w0));
    chk("R8 tag held", 32'(req_tag_o), 32'(t0));
    chk("R8 not issued", n_req - b, 0);
    req_ready_i = 1'b1;
    idle(3);
    chk("R8 issued once", n_req - b, 1);
    chk("R4 addr", r_addr[b], 32'h2000_0040);
    cpl(t0, 1'b1);
    idle(4);
    rd(4'h0, d); chk("R10 busy falls", 32'(d[8]), 0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    int b = n_req, ic = irq_cnt;
    wr(4'hC, 32'd0);
    wr(4'h0, 32'h1);
    idle(4);
    chk("R11 no requests", n_req - b, 0);
    chk("R11 irq", irq_cnt - ic, 1);
    rd(4'h0, d);
    chk("R11 idle", 32'(d[8]), 0);
    chk("R11 done", 32'(d[9]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_round;
    t_basic;
    t_exhaust;
    t_backpressure;
    t_zero;
    chk("R5 no live tag reused", dup_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule